// File: doc/BRIEF.md
# Scanline Interrupt and NMI Generator

This block tracks the vertical position of a video raster and generates the two interrupt requests a CPU needs from it. An end-of-line strobe advances a line counter, which wraps at a frame length picked by a 50/60 Hz standard select input. When the counter enters vertical blank, a status byte is raised and, if enabled, a non-maskable interrupt is scheduled. The NMI reaches the CPU after a programmable number of clock cycles.

A separate interrupt path compares the line counter against a programmable line number. It can also qualify a horizontal-timer strobe. Each condition records its own bit in an active-source mask. The IRQ output is presented after a fixed countdown, which is skipped when the CPU is halted waiting for an interrupt. The output is gated by the CPU's interrupt-disable flag and by a global IRQ disable. Individual sources are cleared through a clear input.

Top module: `scanline_irq_gen`

## Requirements
- R1: `vcount` increases by one on each clock where `line_end` is high and holds otherwise. It returns to 0 instead of reaching `NTSC_LINES` when `pal_mode`=0, or `PAL_LINES` when `pal_mode`=1.
- R2: On the edge where `vcount` becomes `SCREEN_H+FIRST_LINE` (the blanking line), `nmi_status` becomes 8'h80, whether or not NMIs are enabled.
- R3: If `nmi_enable` is 1 when the blanking line is entered, `nmi_take` pulses high for exactly one cycle. The pulse comes max(`nmi_delay`,1) cycles after `nmi_status` became 8'h80. If `cpu_waiting` is high in the cycle before, `cpu_wake` pulses along with it. With `nmi_enable`=0 no pulse occurs.
- R4: On the edge where `vcount` becomes `FIRST_LINE`, `nmi_status` returns to 8'h00 and an NMI still counting down is dropped without a pulse.
- R5: With `vtimer_en`=1 and `htimer_en`=0, a line strobe that makes `vcount` equal `irq_line` sets `irq_sources` bit 0. With `htimer_en`=1, line strobes never set bit 0.
- R6: With `htimer_en`=1, an `htimer_hit` pulse sets `irq_sources` bit 1 when `vtimer_en`=0, or when `vtimer_en`=1 and `vcount` equals `irq_line`. In all other cases it is ignored.
- R7: After a source is raised while the CPU is not waiting, `irq_out` rises `IRQ_DELAY` cycles after the edge that sets the source bit.
- R8: If `cpu_waiting` is high when a source is raised, `irq_out` rises on the same edge that sets the source bit, and `cpu_wake` pulses for that one cycle.
- R9: `irq_out` is low while `cpu_irq_mask` or `irq_global_off` is high. A request held back by the mask is presented once the mask clears. A request that completes its countdown while `irq_global_off` is high is discarded.
- R10: A 1 on a `src_clear` bit removes that bit from `irq_sources` at the next edge. `irq_out` is low whenever `irq_sources` is zero.
- R11: After reset `vcount`, `irq_sources`, `irq_out`, `nmi_take` and `cpu_wake` are 0 and `nmi_status` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_end | input | 1 | End-of-scanline strobe |
| htimer_hit | input | 1 | Horizontal timer match strobe |
| pal_mode | input | 1 | 1 selects the longer frame |
| nmi_enable | input | 1 | Request NMI at vertical blank |
| nmi_delay | input | DLY_W | Cycles from blank start to NMI pulse |
| vtimer_en | input | 1 | Line compare enable |
| htimer_en | input | 1 | Horizontal strobe enable |
| irq_line | input | LINE_W | Programmed IRQ line |
| cpu_waiting | input | 1 | CPU halted waiting for an interrupt |
| cpu_irq_mask | input | 1 | CPU interrupt-disable flag |
| irq_global_off | input | 1 | Global IRQ disable |
| src_clear | input | 2 | Clear bits for the source mask (bit 0 line, bit 1 horizontal) |
| vcount | output | LINE_W | Current line number |
| nmi_status | output | 8 | Blanking status byte (8'h80 or 8'h00) |
| nmi_take | output | 1 | One-cycle NMI delivery pulse |
| irq_sources | output | 2 | Active IRQ source mask |
| irq_out | output | 1 | Level IRQ request to the CPU |
| cpu_wake | output | 1 | One-cycle release of the wait state |

## Verification
Several properties are checked on every cycle: the counter wrap for the selected standard, the counter holding between strobes, the status byte at blank entry and at the first visible line, the one-cycle shape of the NMI pulse within blank, and the gating of `irq_out` by both disables and by an empty mask. Other behaviours depend on exact cycle counts or on which line a condition matched. These are shown only by the bench scenarios: the NMI delay for each setting, cancellation of a late NMI, the per-line sweep of the compare in both modes, the three-cycle IRQ countdown against its bypass while waiting, and the discarded request under global disable.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int SRC_V = 0;
  localparam int SRC_H = 1;
  localparam int SRC_W = 2;
  localparam logic [7:0] BLANK_FLAG = 8'h80;
endpackage

// File: rtl/scan_vcounter.sv
module scan_vcounter #(
  parameter int LINE_W     = 9,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312,
  parameter int SCREEN_H   = 224,
  parameter int FIRST_LINE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              pal_mode,
  output logic [LINE_W-1:0] vcount,
  output logic [LINE_W-1:0] vnext,
  output logic              at_blank,
  output logic              at_first
);
  localparam logic [LINE_W:0]   NTSC_LIM   = (LINE_W+1)'(NTSC_LINES);
  localparam logic [LINE_W:0]   PAL_LIM    = (LINE_W+1)'(PAL_LINES);
  localparam logic [LINE_W-1:0] BLANK_LINE = LINE_W'(SCREEN_H + FIRST_LINE);
  localparam logic [LINE_W-1:0] FIRST_VIS  = LINE_W'(FIRST_LINE);

  logic [LINE_W:0]   inc;
  logic [LINE_W:0]   lim;
  logic [LINE_W-1:0] vcount_d;

  always_comb begin
    lim      = pal_mode ? PAL_LIM : NTSC_LIM;
    inc      = {1'b0, vcount} + 1'b1;
    vnext    = (inc >= lim) ? '0 : inc[LINE_W-1:0];
    vcount_d = line_end ? vnext : vcount;
    at_blank = line_end && (vnext == BLANK_LINE);
    at_first = line_end && (vnext == FIRST_VIS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcount <= '0;
    else        vcount <= vcount_d;
  end
endmodule

// File: rtl/scan_nmi_unit.sv
module scan_nmi_unit #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             at_blank,
  input  logic             at_first,
  input  logic             nmi_enable,
  input  logic [DLY_W-1:0] nmi_delay,
  input  logic             cpu_waiting,
  output logic [7:0]       nmi_status,
  output logic             nmi_take,
  output logic             nmi_wake
);
  import scan_pkg::*;

  logic             pend, pend_d;
  logic [DLY_W-1:0] cnt, cnt_d;
  logic [7:0]       status_d;
  logic             take_d, wake_d;

  always_comb begin
    status_d = nmi_status;
    pend_d   = pend;
    cnt_d    = cnt;
    take_d   = 1'b0;
    wake_d   = 1'b0;
    if (pend) begin
      if (cnt <= DLY_W'(1)) begin
        pend_d = 1'b0;
        take_d = 1'b1;
        wake_d = cpu_waiting;
      end else begin
        cnt_d = cnt - 1'b1;
      end
    end
    if (at_blank) begin
      status_d = BLANK_FLAG;
      if (nmi_enable) begin
        pend_d = 1'b1;
        cnt_d  = nmi_delay;
      end
    end
    if (at_first) begin
      status_d = 8'h00;
      pend_d   = 1'b0;
      take_d   = 1'b0;
      wake_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_status <= 8'h00;
      pend       <= 1'b0;
      cnt        <= '0;
      nmi_take   <= 1'b0;
      nmi_wake   <= 1'b0;
    end else begin
      nmi_status <= status_d;
      pend       <= pend_d;
      cnt        <= cnt_d;
      nmi_take   <= take_d;
      nmi_wake   <= wake_d;
    end
  end
endmodule

// File: rtl/scan_irq_unit.sv
module scan_irq_unit #(
  parameter int LINE_W    = 9,
  parameter int IRQ_DELAY = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        line_end,
  input  logic                        htimer_hit,
  input  logic [LINE_W-1:0]           vcount,
  input  logic [LINE_W-1:0]           vnext,
  input  logic                        vtimer_en,
  input  logic                        htimer_en,
  input  logic [LINE_W-1:0]           irq_line,
  input  logic                        cpu_waiting,
  input  logic                        cpu_irq_mask,
  input  logic                        irq_global_off,
  input  logic [scan_pkg::SRC_W-1:0]  src_clear,
  output logic [scan_pkg::SRC_W-1:0]  irq_sources,
  output logic                        irq_out,
  output logic                        irq_wake
);
  import scan_pkg::*;

  localparam int CW = $clog2(IRQ_DELAY + 1) + 1;

  logic [SRC_W-1:0] raise_bits, act_d;
  logic             pend, pend_d;
  logic [CW-1:0]    cnt, cnt_d;
  logic             wake_d;

  always_comb begin
    raise_bits        = '0;
    raise_bits[SRC_V] = line_end && vtimer_en && !htimer_en && (vnext == irq_line);
    raise_bits[SRC_H] = htimer_hit && htimer_en && (!vtimer_en || (vcount == irq_line));
    act_d  = (irq_sources & ~src_clear) | raise_bits;
    pend_d = pend;
    cnt_d  = cnt;
    wake_d = 1'b0;
    if (|raise_bits) begin
      pend_d = 1'b1;
      cnt_d  = cpu_waiting ? '0 : CW'(IRQ_DELAY);
      wake_d = cpu_waiting;
    end else if (pend) begin
      if (cnt == '0) begin
        if ((irq_sources == '0) || irq_global_off) pend_d = 1'b0;
      end else begin
        cnt_d = cnt - 1'b1;
      end
    end
    irq_out = pend && (cnt == '0) && (|irq_sources) && !irq_global_off && !cpu_irq_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_sources <= '0;
      pend        <= 1'b0;
      cnt         <= '0;
      irq_wake    <= 1'b0;
    end else begin
      irq_sources <= act_d;
      pend        <= pend_d;
      cnt         <= cnt_d;
      irq_wake    <= wake_d;
    end
  end
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen #(
  parameter int LINE_W     = 9,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312,
  parameter int SCREEN_H   = 224,
  parameter int FIRST_LINE = 1,
  parameter int DLY_W      = 8,
  parameter int IRQ_DELAY  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              htimer_hit,
  input  logic              pal_mode,
  input  logic              nmi_enable,
  input  logic [DLY_W-1:0]  nmi_delay,
  input  logic              vtimer_en,
  input  logic              htimer_en,
  input  logic [LINE_W-1:0] irq_line,
  input  logic              cpu_waiting,
  input  logic              cpu_irq_mask,
  input  logic              irq_global_off,
  input  logic [1:0]        src_clear,
  output logic [LINE_W-1:0] vcount,
  output logic [7:0]        nmi_status,
  output logic              nmi_take,
  output logic [1:0]        irq_sources,
  output logic              irq_out,
  output logic              cpu_wake
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [LINE_W-1:0] vnext;
  logic              at_blank, at_first;
  logic              nmi_wake, irq_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  scan_vcounter #(
    .LINE_W(LINE_W), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
    .SCREEN_H(SCREEN_H), .FIRST_LINE(FIRST_LINE)
  ) u_vcnt (
    .clk(clk), .rst_n(rst_int_n), .line_end(line_end), .pal_mode(pal_mode),
    .vcount(vcount), .vnext(vnext), .at_blank(at_blank), .at_first(at_first)
  );

  scan_nmi_unit #(.DLY_W(DLY_W)) u_nmi (
    .clk(clk), .rst_n(rst_int_n), .at_blank(at_blank), .at_first(at_first),
    .nmi_enable(nmi_enable), .nmi_delay(nmi_delay), .cpu_waiting(cpu_waiting),
    .nmi_status(nmi_status), .nmi_take(nmi_take), .nmi_wake(nmi_wake)
  );

  scan_irq_unit #(.LINE_W(LINE_W), .IRQ_DELAY(IRQ_DELAY)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .line_end(line_end), .htimer_hit(htimer_hit),
    .vcount(vcount), .vnext(vnext), .vtimer_en(vtimer_en), .htimer_en(htimer_en),
    .irq_line(irq_line), .cpu_waiting(cpu_waiting), .cpu_irq_mask(cpu_irq_mask),
    .irq_global_off(irq_global_off), .src_clear(src_clear),
    .irq_sources(irq_sources), .irq_out(irq_out), .irq_wake(irq_wake)
  );

  assign cpu_wake = nmi_wake | irq_wake;
endmodule

// File: rtl/scanline_irq_gen_chk.sv
module scanline_irq_gen_chk #(
  parameter int LINE_W     = 9,
  parameter int NTSC_LINES = 262,
  parameter int PAL_LINES  = 312,
  parameter int SCREEN_H   = 224,
  parameter int FIRST_LINE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_end,
  input logic              pal_mode,
  input logic              cpu_waiting,
  input logic              cpu_irq_mask,
  input logic              irq_global_off,
  input logic [LINE_W-1:0] vcount,
  input logic [7:0]        nmi_status,
  input logic              nmi_take,
  input logic [1:0]        irq_sources,
  input logic              irq_out,
  input logic              cpu_wake
);
  localparam logic [LINE_W-1:0] NTSC_TOP   = LINE_W'(NTSC_LINES - 1);
  localparam logic [LINE_W-1:0] PAL_TOP    = LINE_W'(PAL_LINES - 1);
  localparam logic [LINE_W-1:0] PRE_BLANK  = LINE_W'(SCREEN_H + FIRST_LINE - 1);
  localparam logic [LINE_W-1:0] PRE_FIRST  = LINE_W'(FIRST_LINE - 1);

  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && (vcount == (pal_mode ? PAL_TOP : NTSC_TOP))) |=> (vcount == '0));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vcount));

  assert_blank_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && (vcount == PRE_BLANK)) |=> (nmi_status == 8'h80));

  assert_nmi_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> (nmi_status == 8'h80) ##1 !nmi_take);

  assert_first_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && (vcount == PRE_FIRST)) |=> (nmi_status == 8'h00 && !nmi_take));

  assert_wake_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wake |-> $past(cpu_waiting));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq_mask || irq_global_off) |-> !irq_out);

  assert_empty_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sources == 2'b00) |-> !irq_out);
endmodule

bind scanline_irq_gen scanline_irq_gen_chk #(
  .LINE_W(LINE_W), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
  .SCREEN_H(SCREEN_H), .FIRST_LINE(FIRST_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_end(line_end), .pal_mode(pal_mode),
  .cpu_waiting(cpu_waiting), .cpu_irq_mask(cpu_irq_mask),
  .irq_global_off(irq_global_off), .vcount(vcount), .nmi_status(nmi_status),
  .nmi_take(nmi_take), .irq_sources(irq_sources), .irq_out(irq_out),
  .cpu_wake(cpu_wake)
);

// File: tb/sim_scanline_irq_gen.sv
module sim_scanline_irq_gen;
  localparam int LW = 4;
  localparam int NT = 8;
  localparam int PL = 10;
  localparam int SH = 4;
  localparam int FL = 1;
  localparam int DW = 4;
  localparam int ID = 3;
  localparam int VB = SH + FL;

  logic          clk = 1'b0;
  logic          rst_n, line_end, htimer_hit, pal_mode, nmi_enable;
  logic [DW-1:0] nmi_delay;
  logic          vtimer_en, htimer_en, cpu_waiting, cpu_irq_mask, irq_global_off;
  logic [LW-1:0] irq_line;
  logic [1:0]    src_clear;
  logic [LW-1:0] vcount;
  logic [7:0]    nmi_status;
  logic          nmi_take, irq_out, cpu_wake;
  logic [1:0]    irq_sources;

  int checks = 0;
  int fails  = 0;
  int mv     = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  scanline_irq_gen #(
    .LINE_W(LW), .NTSC_LINES(NT), .PAL_LINES(PL), .SCREEN_H(SH),
    .FIRST_LINE(FL), .DLY_W(DW), .IRQ_DELAY(ID)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .htimer_hit(htimer_hit),
    .pal_mode(pal_mode), .nmi_enable(nmi_enable), .nmi_delay(nmi_delay),
    .vtimer_en(vtimer_en), .htimer_en(htimer_en), .irq_line(irq_line),
    .cpu_waiting(cpu_waiting), .cpu_irq_mask(cpu_irq_mask),
    .irq_global_off(irq_global_off), .src_clear(src_clear),
    .vcount(vcount), .nmi_status(nmi_status), .nmi_take(nmi_take),
    .irq_sources(irq_sources), .irq_out(irq_out), .cpu_wake(cpu_wake)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic line();
    line_end = 1'b1;
    tick();
    line_end = 1'b0;
    mv = (mv + 1 >= (pal_mode ? PL : NT)) ? 0 : mv + 1;
  endtask

  task automatic goto_line(int t);
    while (mv != t) line();
  endtask

  task automatic clear_src();
    src_clear = 2'b11;
    tick();
    src_clear = 2'b00;
    tick();
  endtask

  task automatic hhit();
    htimer_hit = 1'b1;
    tick();
    htimer_hit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_end = 0; htimer_hit = 0; pal_mode = 0; nmi_enable = 0;
    nmi_delay = '0; vtimer_en = 0; htimer_en = 0; irq_line = '0; cpu_waiting = 0;
    cpu_irq_mask = 0; irq_global_off = 0; src_clear = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R11 reset state
    chk("R11 vcount", int'(vcount), 0);
    chk("R11 nmi_status", int'(nmi_status), 0);
    chk("R11 irq_sources", int'(irq_sources), 0);
    chk("R11 irq_out", int'(irq_out), 0);
    chk("R11 nmi_take", int'(nmi_take), 0);
    chk("R11 cpu_wake", int'(cpu_wake), 0);

    // R1 counting and wrap, both standards
    for (int i = 0; i < 20; i++) begin
      line();
      chk("R1 ntsc count", int'(vcount), mv);
    end
    repeat (3) tick();
    chk("R1 hold", int'(vcount), mv);
    goto_line(0);
    pal_mode = 1'b1;
    for (int i = 0; i < 25; i++) begin
      line();
      chk("R1 pal count", int'(vcount), mv);
    end
    goto_line(0);
    pal_mode = 1'b0;

    // R2 / R3 NMI delay sweep
    nmi_enable = 1'b1;
    for (int d = 0; d < 6; d++) begin
      int first_at;
      int seen;
      first_at = 0;
      seen = 0;
      nmi_delay = DW'(d);
      goto_line(VB - 1);
      line();
      chk("R2 blank status", int'(nmi_status), 8'h80);
      for (int i = 1; i <= 8; i++) begin
        tick();
        if (nmi_take) begin
          seen++;
          if (first_at == 0) first_at = i;
        end
      end
      chk("R3 nmi delay", first_at, (d < 1) ? 1 : d);
      chk("R3 single pulse", seen, 1);
    end

    // R3 wake with NMI delivery
    nmi_delay = DW'(2);
    goto_line(VB - 1);
    cpu_waiting = 1'b1;
    line();
    tick();
    tick();
    chk("R3 nmi_take with wait", int'(nmi_take), 1);
    chk("R3 wake with nmi", int'(cpu_wake), 1);
    cpu_waiting = 1'b0;

    // R3 disabled NMI still sets status
    nmi_enable = 1'b0;
    goto_line(VB - 1);
    line();
    chk("R2 status with nmi off", int'(nmi_status), 8'h80);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 10; i++) begin
        tick();
        if (nmi_take) seen++;
      end
      chk("R3 no pulse when disabled", seen, 0);
    end

    // R4 cancellation of a late NMI at first visible line
    nmi_enable = 1'b1;
    nmi_delay = DW'(15);
    goto_line(VB - 1);
    line();
    begin
      int seen;
      seen = 0;
      while (mv != 0) begin
        line();
        if (nmi_take) seen++;
      end
      chk("R4 status kept until first line", int'(nmi_status), 8'h80);
      line();
      chk("R4 status cleared", int'(nmi_status), 0);
      for (int i = 0; i < 20; i++) begin
        tick();
        if (nmi_take) seen++;
      end
      chk("R4 nmi cancelled", seen, 0);
    end
    nmi_enable = 1'b0;

    // R5 line compare sweep
    vtimer_en = 1'b1;
    htimer_en = 1'b0;
    for (int l = 0; l < NT; l++) begin
      int at;
      at = -1;
      irq_line = LW'(l);
      clear_src();
      for (int n = 0; n < NT; n++) begin
        line();
        if (irq_sources[0] && at < 0) at = mv;
      end
      chk("R5 match line", at, l);
      chk("R5 no horizontal bit", int'(irq_sources[1]), 0);
    end
    htimer_en = 1'b1;
    clear_src();
    for (int n = 0; n < NT; n++) line();
    chk("R5 blocked by htimer_en", int'(irq_sources[0]), 0);

    // R7 delay then R10 clear
    htimer_en = 1'b0;
    irq_line = LW'(3);
    goto_line(2);
    clear_src();
    line();
    chk("R7 source set", int'(irq_sources[0]), 1);
    tick();
    tick();
    chk("R7 still low", int'(irq_out), 0);
    tick();
    chk("R7 raised", int'(irq_out), 1);
    src_clear = 2'b01;
    tick();
    src_clear = 2'b00;
    chk("R10 sources empty", int'(irq_sources), 0);
    chk("R10 irq_out low", int'(irq_out), 0);

    // R6 horizontal strobe sweep
    htimer_en = 1'b1;
    vtimer_en = 1'b1;
    irq_line = LW'(2);
    for (int n = 0; n < NT; n++) begin
      clear_src();
      hhit();
      chk("R6 h+v match", int'(irq_sources[1]), (mv == 2) ? 1 : 0);
      chk("R6 no line bit", int'(irq_sources[0]), 0);
      line();
    end
    vtimer_en = 1'b0;
    goto_line(6);
    clear_src();
    hhit();
    chk("R6 h only any line", int'(irq_sources[1]), 1);
    htimer_en = 1'b0;
    clear_src();
    hhit();
    chk("R6 ignored when off", int'(irq_sources[1]), 0);

    // R8 fast path while waiting
    htimer_en = 1'b1;
    clear_src();
    repeat (5) tick();
    cpu_waiting = 1'b1;
    hhit();
    chk("R8 immediate irq", int'(irq_out), 1);
    chk("R8 wake pulse", int'(cpu_wake), 1);
    cpu_waiting = 1'b0;
    tick();
    chk("R8 wake single", int'(cpu_wake), 0);

    // R9 mask holds request, global off discards it
    clear_src();
    repeat (5) tick();
    cpu_irq_mask = 1'b1;
    hhit();
    repeat (6) tick();
    chk("R9 masked", int'(irq_out), 0);
    cpu_irq_mask = 1'b0;
    tick();
    chk("R9 released by mask", int'(irq_out), 1);
    clear_src();
    repeat (5) tick();
    irq_global_off = 1'b1;
    hhit();
    repeat (6) tick();
    chk("R9 global off", int'(irq_out), 0);
    chk("R9 source kept", int'(irq_sources[1]), 1);
    irq_global_off = 1'b0;
    tick();
    chk("R9 request discarded", int'(irq_out), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule